// File: doc/BRIEF.md
# Split-Completion Interrupt Processor Interface

This block sits between a set of interrupt sources and one processor core. Each source has an ID and a priority. When a source is pending, not already in service, and more urgent than whatever the core is running, the block raises a single request line. The core talks to the block through a small register window. Reading the acknowledge register claims the most urgent candidate. Writing its ID back completes it.

Completion can take one step or two, and a control bit chooses which. In the one-step scheme, the end-of-interrupt write both drops the running priority and retires the ID. In the two-step scheme, the end-of-interrupt write only drops the priority. The ID stays in service until software writes it to a separate deactivate register placed 4 KB into the window. This lets one agent lower the priority early and hand the final retirement to another. Running priorities are kept on a small stack, so a more urgent interrupt can preempt the one in service.

Top module: `irq_cpu_if`

## Requirements
- R1: Control bit 0 gates signalling. While it is 0, `irq_out` stays low and an acknowledge read returns 1023 without changing any state.
- R2: A control write (offset 0x000) keeps bits 0, 5, 6, 7, 8 and 9 and clears every other bit. A control read returns exactly the kept bits, so read value = written value AND 0x3E1.
- R3: An acknowledge read (offset 0x00C) returns, in bits 9:0 with the upper bits zero, the candidate ID with the numerically lowest priority. Ties go to the lowest ID. The read returns 1023 when there is no candidate. `irq_out` is registered and shows one cycle later whether a candidate exists.
- R4: A successful acknowledge clears that ID's pending bit, marks it active and pushes its priority. After that, only IDs with a strictly lower priority value are candidates.
- R5: An active ID is never a candidate, even if it is pending again.
- R6: With control bit 9 at 0, an end-of-interrupt write (offset 0x010, ID in bits 9:0) naming the most recently acknowledged, not yet dropped ID pops the priority and clears that ID's active state.
- R7: With control bit 9 at 1, the same end-of-interrupt write only pops the priority. The ID stays active, and other IDs at the dropped priority become candidates.
- R8: With control bit 9 at 1, a deactivate write (offset 0x1000, ID in bits 9:0) to an in-range active ID clears its active state, so it can be signalled again.
- R9: A deactivate write while control bit 9 is 0 changes nothing.
- R10: An end-of-interrupt write is ignored when the priority stack is empty or the ID is not the top entry. Deactivate writes naming an ID at or above NUM_IDS are ignored.
- R11: A pulse on `irq_set[i]` makes ID i pending, and a set in the same cycle as that ID's acknowledge leaves it pending. While the priority stack holds STACK_DEPTH entries, nothing is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | NUM_IDS | One-cycle pulses that make IDs pending |
| irq_prio | input | NUM_IDS*PRIO_W | Priority of each ID, ID i in bits [i*PRIO_W +: PRIO_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe, held otherwise |
| irq_out | output | 1 | Registered interrupt request to the core |

## Verification
The bench builds the block with 20 IDs, 4-bit priorities and a stack depth of 3. With 20 IDs the selection tree is padded to 32 leaves, so the unused leaves are exercised. The ID range check also meets IDs that fit in the index width but are not implemented. The depth of 3 makes the full-stack stall reachable with a short chain of nested preemptions. Priorities repeat every five IDs, which produces the equal-priority ties that decide both the lowest-ID rule and the split-mode drop behaviour.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  // Register window offsets (bytes)
  localparam int CTRL_OFS = 'h000;
  localparam int ACK_OFS  = 'h00C;
  localparam int EOI_OFS  = 'h010;
  localparam int DIR_OFS  = 'h1000;

  // Control fields
  localparam int EN_BIT    = 0;
  localparam int SPLIT_BIT = 9;
  localparam logic [31:0] CTRL_KEEP = 32'h0000_03E1;

  // Acknowledge encoding
  localparam int IAR_W    = 10;
  localparam int SPURIOUS = 1023;
endpackage

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NUM_IDS = 32,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10
) (
  input  logic [NUM_IDS-1:0]        cand,
  input  logic [NUM_IDS*PRIO_W-1:0] prio_flat,
  output logic                      best_v,
  output logic [PRIO_W-1:0]         best_prio,
  output logic [ID_W-1:0]           best_id
);
  localparam int LEVELS = $clog2(NUM_IDS);
  localparam int NP     = 1 << LEVELS;

  // Pairwise reduction tree; left operand always carries the lower IDs.
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int N = NP >> l;
    logic [N-1:0]      v;
    logic [PRIO_W-1:0] p  [N];
    logic [ID_W-1:0]   id [N];

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < N; i++) begin : g_in
        if (i < NUM_IDS) begin : g_real
          assign v[i]  = cand[i];
          assign p[i]  = prio_flat[i*PRIO_W +: PRIO_W];
          assign id[i] = ID_W'(i);
        end else begin : g_pad
          assign v[i]  = 1'b0;
          assign p[i]  = '1;
          assign id[i] = '0;
        end
      end
    end else begin : g_merge
      for (genvar i = 0; i < N; i++) begin : g_pair
        logic left_wins;
        assign left_wins = g_lvl[l-1].v[2*i] &&
                           (!g_lvl[l-1].v[2*i+1] ||
                            (g_lvl[l-1].p[2*i] <= g_lvl[l-1].p[2*i+1]));
        assign v[i]  = g_lvl[l-1].v[2*i] | g_lvl[l-1].v[2*i+1];
        assign p[i]  = left_wins ? g_lvl[l-1].p[2*i]  : g_lvl[l-1].p[2*i+1];
        assign id[i] = left_wins ? g_lvl[l-1].id[2*i] : g_lvl[l-1].id[2*i+1];
      end
    end
  end

  assign best_v    = g_lvl[LEVELS].v[0];
  assign best_prio = g_lvl[LEVELS].p[0];
  assign best_id   = g_lvl[LEVELS].id[0];
endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank #(
  parameter int NUM_IDS = 32,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] set_vec,
  input  logic               ack_en,
  input  logic [IDX_W-1:0]   ack_idx,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_IDS-1:0] pending,
  output logic [NUM_IDS-1:0] active
);
  logic [NUM_IDS-1:0] pend_q, act_q, pend_d, act_d;
  logic [NUM_IDS-1:0] ack_hit, clr_hit;

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_dec
    assign ack_hit[i] = ack_en && (ack_idx == IDX_W'(i));
    assign clr_hit[i] = clr_en && (clr_idx == IDX_W'(i));
  end

  // A new request arriving with the acknowledge of the same ID survives it.
  always_comb begin
    pend_d = (pend_q & ~ack_hit) | set_vec;
    act_d  = (act_q & ~clr_hit) | ack_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pending = pend_q;
  assign active  = act_q;
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 10,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic [ID_W-1:0]   push_id,
  input  logic              pop,
  output logic              empty,
  output logic              full,
  output logic [PRIO_W-1:0] top_prio,
  output logic [ID_W-1:0]   top_id,
  output logic [CNT_W-1:0]  count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] prio_mem [DEPTH];
  logic [ID_W-1:0]   id_mem   [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  wr_ptr, top_ptr;

  assign wr_ptr  = PTR_W'(cnt_q);
  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));

  // Storage carries no reset so it can map onto RAM cells.
  always_ff @(posedge clk) begin
    if (push && !full) begin
      prio_mem[wr_ptr] <= push_prio;
      id_mem[wr_ptr]   <= push_id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (push && !full) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_prio = empty ? '0 : prio_mem[top_ptr];
  assign top_id   = empty ? '0 : id_mem[top_ptr];
  assign count    = cnt_q;
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_pkg::*;
#(
  parameter int NUM_IDS     = 32,
  parameter int PRIO_W      = 8,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IDS-1:0]        irq_set,
  input  logic [NUM_IDS*PRIO_W-1:0] irq_prio,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq_out
);
  localparam int IDX_W = $clog2(NUM_IDS);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_en, ctrl_split;
  logic              do_wr, do_rd;
  logic              hit_ctrl, hit_ack, hit_eoi, hit_dir;
  logic [IAR_W-1:0]  wid;
  logic              wid_ok;
  logic [IDX_W-1:0]  widx;

  logic [NUM_IDS-1:0] pending, active, cand;
  logic               best_v;
  logic [PRIO_W-1:0]  best_prio;
  logic [IAR_W-1:0]   best_id;

  logic              stk_empty, stk_full;
  logic [PRIO_W-1:0] stk_top_prio;
  logic [IAR_W-1:0]  stk_top_id;
  logic [CNT_W-1:0]  stk_cnt;
  logic [PRIO_W:0]   run_prio;

  logic can_take, ack_fire, eoi_fire, dir_fire, clr_en;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  // Bus decode
  assign do_wr    = bus_wr;
  assign do_rd    = bus_rd && !bus_wr;
  assign hit_ctrl = (bus_addr == ADDR_W'(CTRL_OFS));
  assign hit_ack  = (bus_addr == ADDR_W'(ACK_OFS));
  assign hit_eoi  = (bus_addr == ADDR_W'(EOI_OFS));
  assign hit_dir  = (bus_addr == ADDR_W'(DIR_OFS));
  assign wid      = bus_wdata[IAR_W-1:0];
  assign wid_ok   = (32'(wid) < 32'(NUM_IDS));
  assign widx     = wid[IDX_W-1:0];

  assign ctrl_en    = ctrl_q[EN_BIT];
  assign ctrl_split = ctrl_q[SPLIT_BIT];

  // Candidate selection
  assign cand = pending & ~active;

  irq_prio_select #(
    .NUM_IDS (NUM_IDS),
    .PRIO_W  (PRIO_W),
    .ID_W    (IAR_W)
  ) u_select (
    .cand      (cand),
    .prio_flat (irq_prio),
    .best_v    (best_v),
    .best_prio (best_prio),
    .best_id   (best_id)
  );

  // Idle running priority sits one step above every encodable priority.
  assign run_prio = stk_empty ? {1'b1, {PRIO_W{1'b0}}} : {1'b0, stk_top_prio};
  assign can_take = ctrl_en && best_v && ({1'b0, best_prio} < run_prio) && !stk_full;

  // Register actions
  assign ack_fire = do_rd && hit_ack && can_take;
  assign eoi_fire = do_wr && hit_eoi && !stk_empty && (wid == stk_top_id);
  assign dir_fire = do_wr && hit_dir && ctrl_split && wid_ok && active[widx];
  assign clr_en   = (eoi_fire && !ctrl_split) || dir_fire;

  irq_state_bank #(
    .NUM_IDS (NUM_IDS),
    .IDX_W   (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (irq_set),
    .ack_en  (ack_fire),
    .ack_idx (best_id[IDX_W-1:0]),
    .clr_en  (clr_en),
    .clr_idx (widx),
    .pending (pending),
    .active  (active)
  );

  irq_prio_stack #(
    .DEPTH  (STACK_DEPTH),
    .PRIO_W (PRIO_W),
    .ID_W   (IAR_W),
    .CNT_W  (CNT_W)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (ack_fire),
    .push_prio (best_prio),
    .push_id   (best_id),
    .pop       (eoi_fire),
    .empty     (stk_empty),
    .full      (stk_full),
    .top_prio  (stk_top_prio),
    .top_id    (stk_top_id),
    .count     (stk_cnt)
  );

  // Control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (do_wr && hit_ctrl) begin
      ctrl_q <= bus_wdata & DATA_W'(CTRL_KEEP);
    end
  end

  // Registered read data and request line
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= can_take;
      if (do_rd) begin
        if (hit_ctrl) begin
          rdata_q <= ctrl_q;
        end else if (hit_ack) begin
          rdata_q <= can_take ? DATA_W'(best_id) : DATA_W'(SPURIOUS);
        end else begin
          rdata_q <= '0;
        end
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/irq_cpu_if_checker.sv
module irq_cpu_if_checker #(
  parameter int NUM_IDS     = 32,
  parameter int STACK_DEPTH = 8,
  parameter int ADDR_W      = 13,
  parameter int IDX_W       = $clog2(NUM_IDS),
  parameter int CNT_W       = $clog2(STACK_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               irq_out,
  input logic               ctrl_en,
  input logic               ctrl_split,
  input logic [NUM_IDS-1:0] active,
  input logic               ack_fire,
  input logic               eoi_fire,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [IDX_W-1:0]   widx,
  input logic [CNT_W-1:0]   stk_cnt
);
  logic dir_write;
  assign dir_write = bus_wr && (bus_addr == ADDR_W'(irq_cpu_pkg::DIR_OFS));

  a_r1_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(ctrl_en));

  a_r4_ack_pushes: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> (stk_cnt == $past(stk_cnt) + 1'b1));

  a_r4_ack_marks_active: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> ($countones(active) == $countones($past(active)) + 1));

  a_r6_unified_eoi_retires: assert property (@(posedge clk) disable iff (rst)
    (eoi_fire && !ctrl_split) |=> !active[$past(widx)]);

  a_r7_split_eoi_keeps_active: assert property (@(posedge clk) disable iff (rst)
    (eoi_fire && ctrl_split) |=> (active == $past(active)));

  a_r7_eoi_pops: assert property (@(posedge clk) disable iff (rst)
    eoi_fire |=> (stk_cnt == $past(stk_cnt) - 1'b1));

  a_r9_dir_ignored_unified: assert property (@(posedge clk) disable iff (rst)
    (dir_write && !ctrl_split) |=> $stable(active));

  a_r11_stack_bound: assert property (@(posedge clk) disable iff (rst)
    stk_cnt <= CNT_W'(STACK_DEPTH));
endmodule

bind irq_cpu_if irq_cpu_if_checker #(
  .NUM_IDS     (NUM_IDS),
  .STACK_DEPTH (STACK_DEPTH),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_out    (irq_out),
  .ctrl_en    (ctrl_en),
  .ctrl_split (ctrl_split),
  .active     (active),
  .ack_fire   (ack_fire),
  .eoi_fire   (eoi_fire),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .widx       (widx),
  .stk_cnt    (stk_cnt)
);

// File: tb/irq_cpu_if_bench.sv
module irq_cpu_if_bench;
  localparam int NUM   = 20;
  localparam int PW    = 4;
  localparam int DEPTH = 3;
  localparam int AW    = 13;
  localparam int DW    = 32;
  localparam int A_CTRL = 'h000, A_ACK = 'h00C, A_EOI = 'h010, A_DIR = 'h1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NUM-1:0]    irq_set = '0;
  logic [NUM*PW-1:0] irq_prio;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              irq_out;

  irq_cpu_if #(
    .NUM_IDS(NUM), .PRIO_W(PW), .STACK_DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)
  ) u_irq_cpu_if (
    .clk(clk), .rst(rst), .irq_set(irq_set), .irq_prio(irq_prio),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  function automatic int prio_of(input int i);
    return (i % 5) * 3 + 1;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_pend[NUM];
  int m_act[NUM];
  int m_sp[$];
  int m_si[$];
  int m_ctrl;
  int exp_irq;
  int exp_rd;

  always @(posedge clk) begin
    int run, bp, bi, a, id;
    bit found, can;
    if (rst) begin
      for (int i = 0; i < NUM; i++) begin m_pend[i] = 0; m_act[i] = 0; end
      m_sp.delete(); m_si.delete();
      m_ctrl = 0; exp_irq = 0; exp_rd = 0;
    end else begin
      run = (m_sp.size() == 0) ? (1 << PW) : m_sp[$];
      found = 0; bp = 0; bi = 0;
      for (int i = 0; i < NUM; i++)
        if (m_pend[i] != 0 && m_act[i] == 0 && (!found || prio_of(i) < bp)) begin
          found = 1; bp = prio_of(i); bi = i;
        end
      can = (m_ctrl & 1) != 0 && found && bp < run && m_sp.size() < DEPTH;
      a = int'(bus_addr);
      id = int'(bus_wdata) & 1023;
      if (bus_rd && !bus_wr) begin
        if (a == A_CTRL) exp_rd = m_ctrl;
        else if (a == A_ACK) begin
          if (can) begin
            exp_rd = bi; m_pend[bi] = 0; m_act[bi] = 1;
            m_sp.push_back(bp); m_si.push_back(bi);
          end else exp_rd = 1023;
        end else exp_rd = 0;
      end
      if (bus_wr) begin
        if (a == A_CTRL) m_ctrl = int'(bus_wdata) & 'h3E1;
        else if (a == A_EOI) begin
          if (m_si.size() > 0 && id == m_si[$]) begin
            void'(m_sp.pop_back()); void'(m_si.pop_back());
            if ((m_ctrl & 'h200) == 0) m_act[id] = 0;
          end
        end else if (a == A_DIR) begin
          if ((m_ctrl & 'h200) != 0 && id < NUM && m_act[id] != 0) m_act[id] = 0;
        end
      end
      for (int i = 0; i < NUM; i++) if (irq_set[i]) m_pend[i] = 1;
      exp_irq = can ? 1 : 0;
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "irq_out", int'(irq_out), exp_irq);
      check(cur_req, "rdata", int'(bus_rdata), exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input int a, input int d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic read_expect(input int a, input int exp, input string req);
    bus_read(a);
    check(req, "read", int'(bus_rdata), exp);
  endtask

  task automatic raise(input int id);
    @(negedge clk); irq_set[id] = 1'b1;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic irq_expect(input int exp, input string req);
    repeat (2) @(negedge clk);
    check(req, "irq_out level", int'(irq_out), exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < NUM; i++) irq_prio[i*PW +: PW] = PW'(prio_of(i));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // Reset state
    cur_req = "R1";
    @(negedge clk);
    check("R1", "irq_out after reset", int'(irq_out), 0);
    check("R2", "rdata after reset", int'(bus_rdata), 0);
    read_expect(A_CTRL, 0, "R2");

    // R2: only kept bits stored
    cur_req = "R2";
    bus_write(A_CTRL, 32'hFFFF_FFFF);
    read_expect(A_CTRL, 'h3E1, "R2");
    bus_write(A_CTRL, 'h1E0);
    read_expect(A_CTRL, 'h1E0, "R2");

    // R1: disabled interface signals nothing
    cur_req = "R1";
    raise(2);
    irq_expect(0, "R1");
    read_expect(A_ACK, 1023, "R1");
    bus_write(A_CTRL, 'h1E1);
    irq_expect(1, "R3");
    read_expect(A_ACK, 2, "R3");

    // R6 / R10: unified completion
    cur_req = "R6";
    bus_write(A_EOI, 3);              // not top: ignored (R10)
    read_expect(A_ACK, 1023, "R10");  // no ID more urgent than 7 pending
    bus_write(A_EOI, 2);
    raise(5); raise(0); raise(9);
    cur_req = "R3";
    read_expect(A_ACK, 0, "R3");      // tie between 0 and 5 -> 0
    read_expect(A_ACK, 1023, "R4");   // 5 equals running priority
    bus_write(A_EOI, 0);
    read_expect(A_ACK, 5, "R6");
    bus_write(A_EOI, 5);
    read_expect(A_ACK, 9, "R6");
    bus_write(A_EOI, 9);
    read_expect(A_ACK, 1023, "R6");

    // R10: ignored completions
    cur_req = "R10";
    bus_write(A_EOI, 0);              // empty stack
    raise(3);
    read_expect(A_ACK, 3, "R10");
    bus_write(A_EOI, 25);
    bus_write(A_EOI, 4);
    raise(1);
    read_expect(A_ACK, 1, "R4");      // preempts, so stack was untouched
    bus_write(A_EOI, 3);              // not top
    bus_write(A_EOI, 1);
    bus_write(A_EOI, 3);
    read_expect(A_ACK, 1023, "R10");

    // R7 / R5 / R8: split completion
    cur_req = "R7";
    bus_write(A_CTRL, 'h201);
    raise(0); raise(10);
    read_expect(A_ACK, 0, "R7");
    read_expect(A_ACK, 1023, "R7");
    bus_write(A_EOI, 0);
    read_expect(A_ACK, 10, "R7");
    cur_req = "R5";
    raise(0);
    bus_write(A_EOI, 10);
    read_expect(A_ACK, 1023, "R5");   // 0 pending but still active
    irq_expect(0, "R5");
    cur_req = "R8";
    bus_write(A_DIR, 0);
    irq_expect(1, "R8");
    read_expect(A_ACK, 0, "R8");
    bus_write(A_EOI, 0);
    bus_write(A_DIR, 0);
    bus_write(A_DIR, 10);
    bus_write(A_DIR, 25);             // out of range (R10)
    read_expect(A_ACK, 1023, "R8");

    // R9: deactivate ignored in unified mode
    cur_req = "R9";
    bus_write(A_CTRL, 'h001);
    raise(6);
    read_expect(A_ACK, 6, "R9");
    bus_write(A_EOI, 6);              // unified: retires 6
    raise(6);
    read_expect(A_ACK, 6, "R9");
    bus_write(A_DIR, 6);              // no effect
    raise(6);
    read_expect(A_ACK, 1023, "R9");   // still active and running
    bus_write(A_EOI, 6);
    read_expect(A_ACK, 6, "R9");
    bus_write(A_EOI, 6);

    // R11: nesting up to the stack depth
    cur_req = "R11";
    raise(4);  read_expect(A_ACK, 4, "R11");
    raise(3);  read_expect(A_ACK, 3, "R11");
    raise(2);  read_expect(A_ACK, 2, "R11");
    raise(1);
    irq_expect(0, "R11");
    read_expect(A_ACK, 1023, "R11");
    bus_write(A_EOI, 2);
    read_expect(A_ACK, 1, "R11");
    bus_write(A_EOI, 1);
    bus_write(A_EOI, 3);
    bus_write(A_EOI, 4);

    // Mixed pseudo-random traffic against the model
    cur_req = "R4";
    lf = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0, 3'd1: raise(int'(lf[8:4]) % NUM);
        3'd2, 3'd3: bus_read(A_ACK);
        3'd4: bus_write(A_EOI, (m_si.size() > 0 && lf[9]) ? m_si[$] : int'(lf[14:10]));
        3'd5: bus_write(A_DIR, int'(lf[14:10]));
        3'd6: bus_write(A_CTRL, (lf[9] ? 'h201 : 'h001) | (int'(lf[13:10]) << 5));
        default: @(negedge clk);
      endcase
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule